// File: doc/BRIEF.md
# Zero-Bus-Turnaround Pipelined SRAM Controller

This block sits between a user-side command port and an external synchronous SRAM of the zero-bus-turnaround kind, one whose read data leaves through an output register. Every clock the user may present one command: an address, a write flag, write data and a tag. The controller turns it into the memory's active-low select and write strobes, its address bus and its shared data bus. It returns each read's data with the matching tag and a one-cycle valid pulse. The user port has no ready signal, because the controller never stalls. Any order of reads, writes and idle cycles runs at one command per clock.

The timing works as follows. A command accepted at clock edge n appears on the memory pins in the cycle after edge n, and the memory samples it at edge n+1. The write data for that command is placed on the bus `LAG` cycles later and is sampled by the memory one edge after that. `LAG` is 2 when `PIPE_OUT` is 1 (registered memory output) and 1 when `PIPE_OUT` is 0. Read data comes back in the same bus slot. Because reads and writes use the same slot, a read can follow a write, and a write can follow a read, with no dead cycle. The controller captures the read data at the end of that slot.

Top module: `zbt_sram_ctrl`

## Requirements
- R1: While `rstN` is low, `memCeN` and `memWeN` are 1, `rdValid` is 0 and the controller does not drive `memDq`.
- R2: A command accepted at edge n (`cmdValid`=1) is shown in cycle n with `memCeN`=0, `memAddr`=`cmdAddr`, and `memWeN`=0 for a write or 1 for a read. With `cmdValid`=0, both `memCeN` and `memWeN` are 1 in that cycle.
- R3: The write data of a write accepted at edge n is driven on `memDq` throughout cycle n+LAG.
- R4: The controller drives `memDq` only in the write-data cycles of R3. In every other cycle it leaves the bus undriven.
- R5: A read accepted at edge n gives `rdValid`=1 in cycle n+LAG+1, with `rdTag` equal to that command's `cmdTag`. In cycles that match no read, `rdValid` is 0.
- R6: `rdData` returned under R5 equals the value the memory drove in cycle n+LAG. This is the last data written to that address in command order, even when the write was the command just before the read.
- R7: Commands are accepted on every cycle with no stall, for any mix of reads, writes and idles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAddr | input | ADDR_W | Word address |
| cmdWdata | input | DATA_W | Data for a write |
| cmdTag | input | TAG_W | Identifier returned with the read result |
| rdValid | output | 1 | Read result present this cycle |
| rdTag | output | TAG_W | Tag of the returned read |
| rdData | output | DATA_W | Returned read data |
| memCeN | output | 1 | Memory select, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memAddr | output | ADDR_W | Memory address |
| memDq | inout | DATA_W | Shared memory data bus |

## Verification
A stage-delay pipeline that slips by one cycle shows up within `LAG` cycles of the first write. The wrong data lands in the bus slot, and the read that follows the write to the same address returns the old value. A stuck drive enable shows up in the first idle or read slot, where the bus no longer floats to the pulled-up value. A wrong valid or tag pipeline shows as a result pulse one cycle early or late, or with another command's tag, on the very first read. The sweeps place every short read/write order, including write-then-read of one address, against a model memory that follows the same slot timing.

// File: rtl/zbt_ctrl_pkg.sv
package zbt_ctrl_pkg;
  // strobes from control to datapath for the data-bus slot
  typedef struct packed {
    logic busDrive;   // this slot carries write data from the controller
    logic rdCapture;  // this slot carries read data from the memory
  } zbtStrobe_t;
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_ctrl_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int LAG   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdWrite,
  input  logic [TAG_W-1:0] cmdTag,
  output logic             memCeN,
  output logic             memWeN,
  output zbtStrobe_t       strb,
  output logic             rdValid,
  output logic [TAG_W-1:0] rdTag
);
  // stage 0 is the cycle the command sits on the memory pins;
  // stage LAG is the cycle its data occupies the bus
  logic             vPipe   [0:LAG];
  logic             wPipe   [0:LAG];
  logic [TAG_W-1:0] tagPipe [0:LAG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s <= LAG; s++) begin
        vPipe[s]   <= 1'b0;
        wPipe[s]   <= 1'b0;
        tagPipe[s] <= '0;
      end
    end else begin
      vPipe[0]   <= cmdValid;
      wPipe[0]   <= cmdValid & cmdWrite;
      tagPipe[0] <= cmdTag;
      for (int s = 1; s <= LAG; s++) begin
        vPipe[s]   <= vPipe[s-1];
        wPipe[s]   <= wPipe[s-1];
        tagPipe[s] <= tagPipe[s-1];
      end
    end
  end

  assign memCeN = ~vPipe[0];
  assign memWeN = ~(vPipe[0] & wPipe[0]);

  always_comb begin
    strb.busDrive  = vPipe[LAG] & wPipe[LAG];
    strb.rdCapture = vPipe[LAG] & ~wPipe[LAG];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdTag   <= '0;
    end else begin
      rdValid <= strb.rdCapture;
      if (strb.rdCapture) rdTag <= tagPipe[LAG];
    end
  end
endmodule

// File: rtl/zbt_datapath.sv
module zbt_datapath
  import zbt_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 36,
  parameter int LAG    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  zbtStrobe_t        strb,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memDq,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdPipe [0:LAG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      for (int s = 0; s <= LAG; s++) wdPipe[s] <= '0;
    end else begin
      if (cmdValid) addrQ <= cmdAddr;
      if (cmdValid && cmdWrite) wdPipe[0] <= cmdWdata;
      for (int s = 1; s <= LAG; s++) wdPipe[s] <= wdPipe[s-1];
    end
  end

  assign memAddr = addrQ;
  assign memDq   = strb.busDrive ? wdPipe[LAG] : {DATA_W{1'bz}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strb.rdCapture) rdData <= memDq;
  end
endmodule

// File: rtl/zbt_sram_ctrl.sv
module zbt_sram_ctrl
  import zbt_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 36,
  parameter int TAG_W    = 4,
  parameter bit PIPE_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [TAG_W-1:0]  cmdTag,
  output logic              rdValid,
  output logic [TAG_W-1:0]  rdTag,
  output logic [DATA_W-1:0] rdData,
  output logic              memCeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memDq
);
  // bus-slot offset in cycles after the address cycle
  localparam int LAG = PIPE_OUT ? 2 : 1;

  zbtStrobe_t strb;

  zbt_ctrl #(.TAG_W(TAG_W), .LAG(LAG)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdTag(cmdTag), .memCeN(memCeN), .memWeN(memWeN), .strb(strb),
    .rdValid(rdValid), .rdTag(rdTag)
  );

  zbt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAG(LAG)) dp_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .strb(strb),
    .memAddr(memAddr), .memDq(memDq), .rdData(rdData)
  );
endmodule

// File: rtl/zbt_sram_ctrl_chk.sv
module zbt_sram_ctrl_chk #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 36,
  parameter int TAG_W    = 4,
  parameter bit PIPE_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdWrite,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [DATA_W-1:0] cmdWdata,
  input logic [TAG_W-1:0]  cmdTag,
  input logic              memCeN,
  input logic              memWeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDq,
  input logic              rdValid,
  input logic [TAG_W-1:0]  rdTag,
  input logic              busDrive
);
  localparam int LAG  = PIPE_OUT ? 2 : 1;
  localparam int WR_D = LAG + 1;
  localparam int RD_D = LAG + 2;

  // R1
  always @(posedge clk)
    if (!rstN) reset_idle_chk: assert (memCeN && memWeN && !rdValid && !busDrive);

  // R2
  cmd_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (!memCeN && memAddr == $past(cmdAddr) && memWeN == !$past(cmdWrite)));

  // R2
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> (memCeN && memWeN));

  // R3
  wr_slot_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmdValid && cmdWrite, WR_D) |-> memDq == $past(cmdWdata, WR_D));

  // R4
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrive == $past(cmdValid && cmdWrite, WR_D));

  // R5
  rd_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid == $past(cmdValid && !cmdWrite, RD_D));

  // R5
  rd_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> rdTag == $past(cmdTag, RD_D));
endmodule

bind zbt_sram_ctrl zbt_sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .PIPE_OUT(PIPE_OUT)
) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
  .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .cmdTag(cmdTag),
  .memCeN(memCeN), .memWeN(memWeN), .memAddr(memAddr), .memDq(memDq),
  .rdValid(rdValid), .rdTag(rdTag), .busDrive(strb.busDrive)
);

// File: tb/zbt_sram_ctrl_tb_top.sv
module zbt_sram_ctrl_tb_top;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int TW  = 4;
  localparam bit PO  = 1'b1;
  localparam int LAG = PO ? 2 : 1;
  localparam int HN  = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdWrite = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdWdata = '0;
  logic [TW-1:0] cmdTag = '0;
  logic rdValid, memCeN, memWeN;
  logic [TW-1:0] rdTag;
  logic [DW-1:0] rdData;
  logic [AW-1:0] memAddr;
  tri   [DW-1:0] memDq;

  always #2.5 clk = ~clk;

  zbt_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .PIPE_OUT(PO)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .cmdTag(cmdTag),
    .rdValid(rdValid), .rdTag(rdTag), .rdData(rdData),
    .memCeN(memCeN), .memWeN(memWeN), .memAddr(memAddr), .memDq(memDq)
  );

  // idle bus floats to all ones; bench write data never equals all ones
  for (genvar b = 0; b < DW; b++) begin : g_pull
    pullup (memDq[b]);
  end

  // behavioural memory with registered output, data slot LAG-1 cycles after address edge
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic          mV [0:LAG-1];
  logic          mW [0:LAG-1];
  logic [AW-1:0] mA [0:LAG-1];
  logic          mDrive = 1'b0;
  logic [DW-1:0] mData = '0;
  assign memDq = mDrive ? mData : {DW{1'bz}};

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    for (int j = 0; j < LAG; j++) begin mV[j] = 1'b0; mW[j] = 1'b0; mA[j] = '0; end
  end

  always @(posedge clk) begin
    if (mV[LAG-1] && mW[LAG-1]) mem[mA[LAG-1]] = memDq;
    for (int j = LAG-1; j > 0; j--) begin mV[j] = mV[j-1]; mW[j] = mW[j-1]; mA[j] = mA[j-1]; end
    mV[0] = !memCeN; mW[0] = !memWeN; mA[0] = memAddr;
    if (mV[LAG-1] && !mW[LAG-1]) begin mDrive <= 1'b1; mData <= mem[mA[LAG-1]]; end
    else mDrive <= 1'b0;
  end

  // command history indexed by accepting edge
  int unsigned nChecks = 0, nErrors = 0;
  int k = 8;
  logic          hV [0:HN-1];
  logic          hW [0:HN-1];
  logic [AW-1:0] hA [0:HN-1];
  logic [DW-1:0] hD [0:HN-1];
  logic [TW-1:0] hT [0:HN-1];
  logic [DW-1:0] refMem [0:(1<<AW)-1];

  initial begin
    for (int i = 0; i < HN; i++) begin hV[i] = 1'b0; hW[i] = 1'b0; hA[i] = '0; hD[i] = '0; hT[i] = '0; end
    for (int i = 0; i < (1<<AW); i++) refMem[i] = '0;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h at k=%0d", req, act, exp, k);
    end
  endtask

  always @(posedge clk) begin
    if (rstN) begin
      int ix;
      k++;
      ix = k % HN;
      hV[ix] = cmdValid; hW[ix] = cmdWrite; hA[ix] = cmdAddr; hT[ix] = cmdTag;
      if (cmdValid && cmdWrite) begin refMem[cmdAddr] = cmdWdata; hD[ix] = cmdWdata; end
      else hD[ix] = refMem[cmdAddr];
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin
      // R1
      check(memCeN === 1'b1 && memWeN === 1'b1, "R1 strobes", {memCeN, memWeN}, 2'b11);
      check(rdValid === 1'b0, "R1 rdValid", rdValid, 0);
      check(memDq === {DW{1'b1}}, "R1 bus", memDq, {DW{1'b1}});
    end else begin
      int i0, iw, ir;
      i0 = k % HN; iw = (k - LAG) % HN; ir = (k - LAG - 1) % HN;
      // R2 / R7
      if (hV[i0]) begin
        check(memCeN === 1'b0 && memWeN === !hW[i0], "R2 R7 strobes", {memCeN, memWeN}, {1'b0, !hW[i0]});
        check(memAddr === hA[i0], "R2 address", memAddr, hA[i0]);
      end else
        check(memCeN === 1'b1 && memWeN === 1'b1, "R2 idle", {memCeN, memWeN}, 2'b11);
      // R3 / R4
      if (hV[iw] && hW[iw])
        check(memDq === hD[iw], "R3 write slot", memDq, hD[iw]);
      else if (!hV[iw])
        check(memDq === {DW{1'b1}}, "R4 bus released", memDq, {DW{1'b1}});
      // R5 / R6
      if (hV[ir] && !hW[ir]) begin
        check(rdValid === 1'b1, "R5 rdValid", rdValid, 1);
        check(rdTag === hT[ir], "R5 rdTag", rdTag, hT[ir]);
        check(rdData === hD[ir], "R6 rdData", rdData, hD[ir]);
      end else
        check(rdValid === 1'b0, "R5 no result", rdValid, 0);
    end
  end

  int unsigned cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nErrors++;
      $display("FAIL R7 watchdog actual=%0d expected<20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  logic [TW-1:0] tagCnt = '0;
  task automatic issue(input bit v, input bit w, input int a, input int d);
    @(negedge clk);
    cmdValid = v; cmdWrite = w; cmdAddr = a[AW-1:0]; cmdWdata = d[DW-1:0];
    cmdTag = tagCnt; tagCnt = tagCnt + 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // fill every address back to back, then read each back (R6, R7)
    for (int a = 0; a < (1<<AW); a++) issue(1, 1, a, (a * 7 + 3) % 255);
    for (int a = 0; a < (1<<AW); a++) issue(1, 0, a, 0);
    // every 5-command read/write order on paired addresses (write-then-read same address)
    for (int p = 0; p < 32; p++) begin
      for (int i = 0; i < 5; i++) issue(1, p[i], 4 + (i >> 1), (p * 9 + i * 13 + 1) % 255);
      if (p % 2 == 1) issue(0, 0, 0, 0);
    end
    // random mix
    for (int n = 0; n < 3000; n++)
      issue(($urandom % 100) < 85, $urandom % 2, $urandom % (1<<AW), $urandom % 255);
    for (int n = 0; n < 8; n++) issue(0, 0, 0, 0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule